// File: doc/BRIEF.md
# PHY Test-Port Parameter Programmer

This block walks a small table of analog trim settings and writes each one into a PHY through a narrow test port. The port has one input word and one read-back register. The input word carries a data byte, a register address and a write-enable bit. Every access to the input word must be followed by settling reads of the read-back register. The block is the hardware counterpart of a bring-up routine. Once the PHY clocks and resets are released, a single start pulse makes it program every trim field in table order. The surrounding logic then sees a one-cycle done pulse.

For every table entry (register number, field msb, field lsb, value) the block first selects the register and samples its read-back. It then builds the field data by shifting the value up to the field position and masking it to the field. The data is written three times, with the write enable raised only on the middle access, so the strobe is bracketed by stable data. The register is then selected again and read once to confirm. Bits outside the field are driven as zero. They are never merged from the read-back. A legacy flag skips programming altogether. Entries that describe an impossible field or an out-of-range register are skipped and flagged.

Top module: `prm_testport_prog`

## Requirements
- R1: The test-port word `tp_word` places the data byte in bits 13:6, the 5-bit register address in bits 5:1 and the write enable in bit 0. It is valid while `tp_wr` is high and is zero otherwise.
- R2: Each write (`tp_wr` high for one cycle) is followed by exactly two settling reads (`tp_rd` high) in the next two cycles. `tp_wr` and `tp_rd` are never high together.
- R3: An entry starts with a select write (data 1, entry address, enable 0) and its two settling reads, then one sampling read.
- R4: The field data is (value << lsb) masked to bits msb..lsb. Value bits that shift outside the field are dropped, and bits outside the field are zero.
- R5: The field is written as three writes of the same data and address: enable 0, enable 1, enable 0. Each write is followed by its settling reads.
- R6: After the field writes the register is selected again (data 1, enable 0), followed by its settling reads and one confirming read. A valid entry therefore takes exactly 17 cycles of port activity.
- R7: Entries 0 to `tbl_cnt`-1 (at most 7) are applied in index order. A count of zero programs nothing and still completes.
- R8: When `legacy` is high at start, no port access occurs and done still pulses.
- R9: A start pulse while a run is in progress is ignored. It neither restarts nor extends the run.
- R10: `done` is high for exactly one cycle after the last entry completes, and never while `busy` is high. `busy` is high only while entries are being processed.
- R11: An entry with msb below lsb, or with a register number above 31, produces no port access, takes one cycle and sets the sticky `err` flag. `err` is cleared when the next start is accepted.
- R12: After reset `busy`, `done`, `err`, `tp_wr` and `tp_rd` are low, and the port is silent whenever the block is not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| legacy | input | 1 | Skip all programming when high at start |
| tbl_cnt | input | 3 | Number of table entries to apply (0..7) |
| tbl_reg | input | 42 | Per-entry register number, 6 bits each, entry i at bits 6i+5..6i |
| tbl_msb | input | 21 | Per-entry field msb, 3 bits each |
| tbl_lsb | input | 21 | Per-entry field lsb, 3 bits each |
| tbl_val | input | 56 | Per-entry field value, 8 bits each |
| tp_word | output | 14 | Test-port input word {data, address, write enable} |
| tp_wr | output | 1 | Write strobe for the test-port input word |
| tp_rd | output | 1 | Read strobe for the test-port read-back register |
| busy | output | 1 | Table processing in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky flag for a skipped malformed entry |

## Verification
The assertions check the port protocol on every cycle. They cover the two settling reads after every write, the exclusive strobes, the enable-high write framed by identical enable-low writes, a silent port outside a run, and a done pulse that is single and never overlaps busy. Other properties need a whole table and are shown only by the bench scenarios: the exact data and address of each access, the masking of oversize values, table order, the legacy and zero-count bypasses, skipping of malformed entries with the error flag, and ignoring a second start.

// File: rtl/prm_pkg.sv
// Package: shared types for the test-port parameter programmer.
// Assumes nothing beyond being compiled before the modules that import it.
package prm_pkg;

    // Kind of port access issued in a cycle
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_WR   = 2'd1,
        OP_RD   = 2'd2
    } op_e;

    // Content of a write access
    typedef enum logic [1:0] {
        WK_SEL = 2'd0,
        WK_DAT = 2'd1,
        WK_STB = 2'd2
    } wkind_e;

    // Phases of the per-entry access sequence, in issue order
    typedef enum logic [2:0] {
        PH_SEL  = 3'd0,
        PH_SMP  = 3'd1,
        PH_DAT  = 3'd2,
        PH_STB  = 3'd3,
        PH_DAT2 = 3'd4,
        PH_RSEL = 3'd5,
        PH_CNF  = 3'd6
    } ph_e;

    // Top-level control states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } st_e;

endpackage

// File: rtl/prm_entry_fmt.sv
// Module: prm_entry_fmt
// Turns one table entry into the masked field data and a validity flag.
// Assumes the register number carries one extra bit above the address
// width, so that out-of-range numbers can be detected. Purely combinational.
module prm_entry_fmt #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W:0]          reg_no,
    input  logic [$clog2(DATA_W)-1:0] msb,
    input  logic [$clog2(DATA_W)-1:0] lsb,
    input  logic [DATA_W-1:0]        value,
    output logic [DATA_W-1:0]        field_data,
    output logic                     ok
);
    localparam int POS_W = $clog2(DATA_W);

    logic [DATA_W-1:0] fmask;
    logic [DATA_W-1:0] shifted;

    // One mask bit per data bit: set when the bit lies within msb..lsb
    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        assign fmask[b] = (POS_W'(b) <= msb) && (POS_W'(b) >= lsb);
    end

    // Shift the value into place and keep only the field bits
    always_comb begin
        shifted    = value << lsb;
        field_data = shifted & fmask;
        ok         = (msb >= lsb) && !reg_no[ADDR_W];
    end

endmodule

// File: rtl/prm_access_seq.sv
// Module: prm_access_seq
// Steps through the fixed per-entry access pattern: select, sample, three
// field writes, re-select, confirm. Every write is trailed by SETTLE_RD reads.
// Assumes adv is high only while the current entry is being programmed.
// clear returns the pattern to its first step.
module prm_access_seq
    import prm_pkg::*;
#(
    parameter int SETTLE_RD = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear,
    input  logic   adv,
    output op_e    op,
    output wkind_e wkind,
    output logic   last
);
    localparam int SUB_W = $clog2(SETTLE_RD + 1);

    ph_e              phase_q;
    logic [SUB_W-1:0] sub_q;
    logic             is_rd_phase;
    logic             phase_end;

    // Decode the access issued in the current step
    always_comb begin
        is_rd_phase = (phase_q == PH_SMP) || (phase_q == PH_CNF);
        phase_end   = is_rd_phase || (sub_q == SUB_W'(SETTLE_RD));
        if (is_rd_phase || (sub_q != '0)) op = OP_RD;
        else                              op = OP_WR;
        case (phase_q)
            PH_SEL, PH_RSEL: wkind = WK_SEL;
            PH_STB:          wkind = WK_STB;
            default:         wkind = WK_DAT;
        endcase
        last = (phase_q == PH_CNF);
    end

    // Advance the phase and settle-read counters
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase_q <= PH_SEL;
            sub_q   <= '0;
        end else if (adv) begin
            if (phase_end) begin
                sub_q   <= '0;
                phase_q <= (phase_q == PH_CNF) ? PH_SEL : ph_e'(phase_q + 3'd1);
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/prm_testport_prog.sv
// Module: prm_testport_prog (top)
// Applies a table of trim fields to a PHY through its test port, one entry
// at a time and in index order. Malformed entries are skipped and flagged.
// Assumes the table inputs stay stable from start until done.
module prm_testport_prog
    import prm_pkg::*;
#(
    parameter int MAX_ENT   = 7,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 5,
    parameter int SETTLE_RD = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                start,
    input  logic                                legacy,
    input  logic [$clog2(MAX_ENT+1)-1:0]        tbl_cnt,
    input  logic [MAX_ENT*(ADDR_W+1)-1:0]       tbl_reg,
    input  logic [MAX_ENT*$clog2(DATA_W)-1:0]   tbl_msb,
    input  logic [MAX_ENT*$clog2(DATA_W)-1:0]   tbl_lsb,
    input  logic [MAX_ENT*DATA_W-1:0]           tbl_val,
    output logic [DATA_W+ADDR_W:0]              tp_word,
    output logic                                tp_wr,
    output logic                                tp_rd,
    output logic                                busy,
    output logic                                done,
    output logic                                err
);
    localparam int CNT_W = $clog2(MAX_ENT + 1);
    localparam int POS_W = $clog2(DATA_W);
    localparam int RNO_W = ADDR_W + 1;

    st_e               state_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_eff;
    logic              err_q;

    logic [RNO_W-1:0]  ent_reg;
    logic [POS_W-1:0]  ent_msb;
    logic [POS_W-1:0]  ent_lsb;
    logic [DATA_W-1:0] ent_val;
    logic [DATA_W-1:0] fdata;
    logic              ent_ok;

    op_e               acc_op;
    wkind_e            acc_kind;
    logic              acc_last;
    logic              run_ok;
    logic              entry_end;
    logic [DATA_W-1:0] wdata;

    // Pick the fields of the entry currently being processed
    always_comb begin
        ent_reg = tbl_reg[idx_q*RNO_W  +: RNO_W];
        ent_msb = tbl_msb[idx_q*POS_W  +: POS_W];
        ent_lsb = tbl_lsb[idx_q*POS_W  +: POS_W];
        ent_val = tbl_val[idx_q*DATA_W +: DATA_W];
        cnt_eff = (tbl_cnt > CNT_W'(MAX_ENT)) ? CNT_W'(MAX_ENT) : tbl_cnt;
    end

    prm_entry_fmt #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_fmt (
        .reg_no     (ent_reg),
        .msb        (ent_msb),
        .lsb        (ent_lsb),
        .value      (ent_val),
        .field_data (fdata),
        .ok         (ent_ok)
    );

    prm_access_seq #(
        .SETTLE_RD (SETTLE_RD)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == ST_IDLE),
        .adv   (run_ok),
        .op    (acc_op),
        .wkind (acc_kind),
        .last  (acc_last)
    );

    // Drive the test port from the current access step
    always_comb begin
        run_ok    = (state_q == ST_RUN) && ent_ok;
        entry_end = (state_q == ST_RUN) && (!ent_ok || acc_last);
        tp_wr     = run_ok && (acc_op == OP_WR);
        tp_rd     = run_ok && (acc_op == OP_RD);
        wdata     = (acc_kind == WK_SEL) ? DATA_W'(1) : fdata;
        tp_word   = tp_wr ? {wdata, ent_reg[ADDR_W-1:0], acc_kind == WK_STB}
                          : '0;
        busy      = (state_q == ST_RUN);
        done      = (state_q == ST_FIN);
        err       = err_q;
    end

    // Control: accept start, walk the entries, flag skips, pulse done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        err_q <= 1'b0;
                        idx_q <= '0;
                        cnt_q <= cnt_eff;
                        if (legacy || (cnt_eff == '0)) state_q <= ST_FIN;
                        else                           state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (entry_end) begin
                        if (!ent_ok) err_q <= 1'b1;
                        if (idx_q == CNT_W'(cnt_q - 1'b1)) state_q <= ST_FIN;
                        else                               idx_q   <= idx_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/prm_testport_prog_chk.sv
// Module: prm_testport_prog_chk
// Protocol checker for the test-port programmer, attached by bind.
// Observes ports only and assumes a synchronous active-low reset.
module prm_testport_prog_chk #(
    parameter int WORD_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              tp_wr,
    input logic              tp_rd,
    input logic [WORD_W-1:0] tp_word
);
    localparam logic [WORD_W-1:0] EN_BIT = WORD_W'(1);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(tp_wr && tp_rd)); // R2

    AST_SETTLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tp_wr) |-> tp_rd); // R2

    AST_SETTLE_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tp_wr, 2) |-> tp_rd); // R2

    AST_STROBE_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_wr && tp_word[0]) |->
            ($past(tp_wr, 3) && ($past(tp_word, 3) == (tp_word & ~EN_BIT)))); // R5

    AST_STROBE_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(tp_wr, 3) && $past(tp_word[0], 3)) |->
            (tp_wr && (tp_word == ($past(tp_word, 3) & ~EN_BIT)))); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tp_wr && !tp_rd)); // R12

endmodule

bind prm_testport_prog prm_testport_prog_chk #(
    .WORD_W (DATA_W + ADDR_W + 1)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .tp_wr   (tp_wr),
    .tp_rd   (tp_rd),
    .tp_word (tp_word)
);

// File: tb/sim_prm_testport_prog.sv
// Bench: directed scenarios, each task checks its own results against a
// port-access log built independently from the requirements.
module sim_prm_testport_prog;
    localparam int MAX_ENT = 7;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 5;
    localparam int LOG_N   = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        legacy = 1'b0;
    logic [2:0]  tbl_cnt = '0;
    logic [41:0] tbl_reg = '0;
    logic [20:0] tbl_msb = '0;
    logic [20:0] tbl_lsb = '0;
    logic [55:0] tbl_val = '0;
    logic [13:0] tp_word;
    logic        tp_wr, tp_rd, busy, done, err;

    int errors = 0;
    int checks = 0;

    // Observed and expected access logs: kind 1 = write, 2 = read
    logic [1:0]  lk [LOG_N];
    logic [13:0] lw [LOG_N];
    logic [1:0]  ek [LOG_N];
    logic [13:0] ew [LOG_N];
    int n_log = 0;
    int n_exp = 0;
    int busy_cyc = 0;
    int done_cyc = 0;

    always #10 clk = ~clk;   // 50 MHz

    prm_testport_prog u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .legacy(legacy),
        .tbl_cnt(tbl_cnt), .tbl_reg(tbl_reg), .tbl_msb(tbl_msb),
        .tbl_lsb(tbl_lsb), .tbl_val(tbl_val), .tp_word(tp_word),
        .tp_wr(tp_wr), .tp_rd(tp_rd), .busy(busy), .done(done), .err(err)
    );

    // Monitor: record port accesses and status activity away from the edge
    always @(negedge clk) begin
        if (tp_wr || tp_rd) begin
            if (n_log < LOG_N) begin
                lk[n_log] = tp_wr ? 2'd1 : 2'd2;
                lw[n_log] = tp_word;
            end
            n_log++;
        end
        if (busy) busy_cyc++;
        if (done) done_cyc++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_ent(input int i, input int rno, input int m, input int l, input int v);
        tbl_reg[i*6 +: 6] = 6'(rno);
        tbl_msb[i*3 +: 3] = 3'(m);
        tbl_lsb[i*3 +: 3] = 3'(l);
        tbl_val[i*8 +: 8] = 8'(v);
    endtask

    function automatic logic [7:0] fdat(input int m, input int l, input int v);
        logic [7:0] mk = '0;
        for (int b = 0; b < 8; b++) if (b <= m && b >= l) mk[b] = 1'b1;
        return 8'((v << l) & mk);
    endfunction

    task automatic push(input logic [1:0] k, input logic [13:0] w);
        if (n_exp < LOG_N) begin ek[n_exp] = k; ew[n_exp] = w; end
        n_exp++;
    endtask

    task automatic push_wr(input logic [13:0] w);
        push(2'd1, w); push(2'd2, '0); push(2'd2, '0);
    endtask

    // Expected accesses of one entry, per R1 to R6; malformed entries add none (R11)
    task automatic exp_ent(input int rno, input int m, input int l, input int v);
        logic [13:0] sel, dw;
        if (m < l || rno > 31) return;
        sel = {8'd1, 5'(rno), 1'b0};
        dw  = {fdat(m, l, v), 5'(rno), 1'b0};
        push_wr(sel); push(2'd2, '0);
        push_wr(dw); push_wr(dw | 14'd1); push_wr(dw);
        push_wr(sel); push(2'd2, '0);
    endtask

    task automatic cmp_seq(input string tag);
        int bad = 0;
        int first = -1;
        chk(n_log == n_exp, {tag, " access count"}, n_log, n_exp);
        for (int i = 0; i < n_exp && i < n_log && i < LOG_N; i++) begin
            if (lk[i] !== ek[i] || (ek[i] == 2'd1 && lw[i] !== ew[i])) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (first >= 0)
            chk(1'b0, {tag, " access content"}, int'(lw[first]), int'(ew[first]));
        else
            chk(1'b1, {tag, " access content"}, 0, 0);
    endtask

    task automatic clear_logs();
        @(posedge clk);
        n_log = 0; n_exp = 0; busy_cyc = 0; done_cyc = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 3000 && done_cyc == 0; i++) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    task automatic load_example();
        set_ent(0, 7, 3, 0, 10);  set_ent(1, 8, 3, 0, 3);
        set_ent(2, 9, 3, 0, 5);   set_ent(3, 11, 3, 0, 9);
        set_ent(4, 13, 6, 5, 2);  set_ent(5, 27, 2, 0, 7);
        set_ent(6, 28, 1, 0, 1);
        tbl_cnt = 3'd7;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!busy && !done && !err, "R12 reset status", {busy, done, err}, 0);
        chk(!tp_wr && !tp_rd && tp_word == '0, "R12 reset port", int'(tp_word), 0);
    endtask

    task automatic t_example();
        clear_logs();
        load_example();
        legacy = 1'b0;
        exp_ent(7, 3, 0, 10); exp_ent(8, 3, 0, 3);  exp_ent(9, 3, 0, 5);
        exp_ent(11, 3, 0, 9); exp_ent(13, 6, 5, 2); exp_ent(27, 2, 0, 7);
        exp_ent(28, 1, 0, 1);
        pulse_start();
        wait_done();
        cmp_seq("R7 R5 R6 example table");
        chk(lw[0] == {8'd1, 5'd7, 1'b0}, "R3 first select word", int'(lw[0]), int'({8'd1, 5'd7, 1'b0}));
        chk(lw[7] == {8'd10, 5'd7, 1'b1}, "R1 strobe word layout", int'(lw[7]), int'({8'd10, 5'd7, 1'b1}));
        chk(lw[4*17+4] == {8'h40, 5'd13, 1'b0}, "R4 shifted field", int'(lw[4*17+4]), int'({8'h40, 5'd13, 1'b0}));
        chk(busy_cyc == 7*17, "R6 busy cycles", busy_cyc, 7*17);
        chk(done_cyc == 1, "R10 single done", done_cyc, 1);
        chk(!err, "R11 no error on clean table", int'(err), 0);
    endtask

    task automatic t_wide_value();
        clear_logs();
        set_ent(0, 26, 7, 4, 5);
        set_ent(1, 13, 6, 5, 255);
        tbl_cnt = 3'd2;
        exp_ent(26, 7, 4, 5); exp_ent(13, 6, 5, 255);
        pulse_start();
        wait_done();
        cmp_seq("R4 wide values");
        chk(lw[17+4] == {8'h60, 5'd13, 1'b0}, "R4 oversize value masked", int'(lw[21]), int'({8'h60, 5'd13, 1'b0}));
    endtask

    task automatic t_legacy();
        clear_logs();
        load_example();
        legacy = 1'b1;
        pulse_start();
        wait_done();
        legacy = 1'b0;
        chk(n_log == 0, "R8 legacy no access", n_log, 0);
        chk(done_cyc == 1 && busy_cyc == 0, "R8 legacy done only", done_cyc*100 + busy_cyc, 100);
    endtask

    task automatic t_invalid();
        clear_logs();
        set_ent(0, 9, 3, 0, 5);
        set_ent(1, 5, 1, 3, 6);
        set_ent(2, 40, 3, 0, 1);
        set_ent(3, 11, 3, 0, 9);
        tbl_cnt = 3'd4;
        exp_ent(9, 3, 0, 5); exp_ent(5, 1, 3, 6); exp_ent(40, 3, 0, 1); exp_ent(11, 3, 0, 9);
        pulse_start();
        wait_done();
        cmp_seq("R11 skipped entries");
        chk(err, "R11 sticky error", int'(err), 1);
        chk(busy_cyc == 2*17 + 2, "R11 skip takes one cycle", busy_cyc, 36);
        // a fresh start with a clean table clears the flag
        clear_logs();
        tbl_cnt = 3'd1;
        pulse_start();
        @(posedge clk);
        @(negedge clk);
        chk(!err, "R11 error cleared on start", int'(err), 0);
        wait_done();
    endtask

    task automatic t_busy_start();
        int seen;
        clear_logs();
        set_ent(0, 7, 3, 0, 6); set_ent(1, 13, 6, 5, 2); set_ent(2, 26, 7, 4, 5);
        tbl_cnt = 3'd3;
        exp_ent(7, 3, 0, 6); exp_ent(13, 6, 5, 2); exp_ent(26, 7, 4, 5);
        pulse_start();
        repeat (20) @(posedge clk);
        pulse_start();
        wait_done();
        repeat (60) @(posedge clk);
        seen = n_log;
        cmp_seq("R9 start while busy");
        chk(done_cyc == 1, "R9 one completion", done_cyc, 1);
        chk(seen == 51 && busy_cyc == 51, "R9 no extension", busy_cyc, 51);
    endtask

    task automatic t_count_zero();
        clear_logs();
        tbl_cnt = 3'd0;
        pulse_start();
        wait_done();
        chk(n_log == 0 && done_cyc == 1, "R7 zero count completes", n_log*100 + done_cyc, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_example();
        t_wide_value();
        t_legacy();
        t_invalid();
        t_busy_start();
        t_count_zero();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule